// File: doc/BRIEF.md
# Lockable Watchdog with Control Register

This block is a watchdog timer driven by a single byte-wide control/status register on a simple write-strobe bus. Software arms the watchdog by setting an arm bit. From then on, no software write can disarm it or hold its counter. The only way to avoid expiry is to write the kick bit before each timeout period ends. Every kick restarts the count.

When the count runs out, the block drives a board reset pulse of fixed length and disarms itself. A strap input chooses whether the same pulse also drives a system-wide reset output. A running output mirrors the armed state so that it can light an indicator. The same register also holds several bits that are not part of the watchdog:
- a bus-timer enable;
- an indicator control bit;
- two sticky bus-error flags;
- a power-fail status bit.

Writing the top bit of the register clears the sticky flags, so a careless write to that bit loses error history. The timeout defaults to 512 ms at a 100 MHz clock.

Top module: `wdog_ctl`

## Requirements
- R1: After reset, rdata_o reads 0x00 while the status inputs are low, and sys_rst_o, ext_rst_o, run_o, bt_en_o and led_o are all 0.
- R2: A write with bit 0 (arm) set while the watchdog is idle and no reset pulse is active arms it. From the next cycle run_o is 1 and rdata_o bit 0 reads 1.
- R3: While the watchdog is armed, a write with bit 0 clear does not disarm it and does not change when it expires.
- R4: A write with bit 1 (kick) set while armed restarts the count. Expiry then falls TIMEOUT_CYC cycles after the last kick edge.
- R5: With no kick, sys_rst_o rises TIMEOUT_CYC cycles after the arming edge and stays high for exactly RST_CYC cycles.
- R6: Expiry disarms the watchdog: run_o is 0 from the first cycle of the reset pulse onward.
- R7: ext_rst_o follows sys_rst_o when strap_sysrst_i is 1, and stays 0 when it is 0.
- R8: Bit 1 always reads 0. A write that sets the arm bit during the reset pulse has no effect, so the watchdog is idle when the pulse ends.
- R9: Bit 2 (bus-timer enable) and bit 3 (indicator) are plain read/write bits that drive bt_en_o and led_o.
- R10: Bits 4 and 5 are sticky flags. They are set in the cycle after berr_a_i or berr_b_i is high, and cleared by a write with bit 7 set; a set at the same edge wins over the clear. Bit 6 reads pwrfail_i, and bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register read data |
| berr_a_i | input | 1 | Bus-error event A |
| berr_b_i | input | 1 | Bus-error event B |
| pwrfail_i | input | 1 | Power-fail status |
| strap_sysrst_i | input | 1 | Strap enabling the system-wide reset |
| sys_rst_o | output | 1 | Board reset pulse on expiry |
| ext_rst_o | output | 1 | System-wide reset pulse on expiry |
| run_o | output | 1 | Watchdog armed (indicator drive) |
| bt_en_o | output | 1 | Bus-timer enable bit |
| led_o | output | 1 | Indicator control bit |

## Verification
Every register write and every status event shows up in rdata_o and in the outputs one cycle after the clock edge that takes it. The bench therefore drives inputs on the falling edge and reads results on the next falling edge. Expiry is due TIMEOUT_CYC edges after the last arm or kick edge, and the bench counts falling edges from that write to land on it. It checks that the pulse is still low one cycle before that point and high exactly at it. It then checks that the pulse stays high for exactly RST_CYC cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 8;
  // register bit positions
  localparam int B_ARM  = 0;
  localparam int B_KICK = 1;
  localparam int B_BTEN = 2;
  localparam int B_LED  = 3;
  localparam int B_ERRA = 4;
  localparam int B_ERRB = 5;
  localparam int B_PWRF = 6;
  localparam int B_CLR  = 7;
endpackage

// File: rtl/wdog_csr.sv
module wdog_csr
  import wdog_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          berr_a_i,
  input  logic          berr_b_i,
  input  logic          pwrfail_i,
  input  logic          expire_i,
  input  logic          busy_i,
  output logic          arm_o,
  output logic          kick_o,
  output logic          bt_en_o,
  output logic          led_o,
  output logic [DW-1:0] rdata_o
);
  logic arm_q, arm_d, bt_q, bt_d, led_q, led_d;
  logic ea_q, ea_d, eb_q, eb_d;

  always_comb begin
    arm_d = arm_q;
    if (wr_i && wdata_i[B_ARM] && !busy_i) arm_d = 1'b1;
    if (expire_i)                          arm_d = 1'b0;
    bt_d  = wr_i ? wdata_i[B_BTEN] : bt_q;
    led_d = wr_i ? wdata_i[B_LED]  : led_q;
    ea_d  = ea_q;
    eb_d  = eb_q;
    if (wr_i && wdata_i[B_CLR]) begin
      ea_d = 1'b0;
      eb_d = 1'b0;
    end
    if (berr_a_i) ea_d = 1'b1;
    if (berr_b_i) eb_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      bt_q  <= 1'b0;
      led_q <= 1'b0;
      ea_q  <= 1'b0;
      eb_q  <= 1'b0;
    end else begin
      arm_q <= arm_d;
      bt_q  <= bt_d;
      led_q <= led_d;
      ea_q  <= ea_d;
      eb_q  <= eb_d;
    end
  end

  assign kick_o  = wr_i && wdata_i[B_KICK] && arm_q;
  assign arm_o   = arm_q;
  assign bt_en_o = bt_q;
  assign led_o   = led_q;

  always_comb begin
    rdata_o         = '0;
    rdata_o[B_ARM]  = arm_q;
    rdata_o[B_BTEN] = bt_q;
    rdata_o[B_LED]  = led_q;
    rdata_o[B_ERRA] = ea_q;
    rdata_o[B_ERRB] = eb_q;
    rdata_o[B_PWRF] = pwrfail_i;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned TIMEOUT_CYC = 51_200_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire_o = arm_i && !kick_i && (cnt_q == LAST);
  assign cnt_en   = arm_i || (cnt_q != '0);

  always_comb begin
    if (!arm_i || kick_i || expire_o) cnt_d = '0;
    else                              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_rstpulse.sv
module wdog_rstpulse #(
  parameter int unsigned RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int RW = $clog2(RST_CYC + 1);

  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          rcnt_en;

  assign pulse_o = (rcnt_q != '0);
  assign rcnt_en = fire_i || pulse_o;

  always_comb begin
    if (fire_i) rcnt_d = RW'(RST_CYC);
    else        rcnt_d = rcnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rcnt_q <= '0;
    else if (rcnt_en) rcnt_q <= rcnt_d;
  end
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl #(
  parameter int unsigned TIMEOUT_CYC = 51_200_000,
  parameter int unsigned RST_CYC     = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       berr_a_i,
  input  logic       berr_b_i,
  input  logic       pwrfail_i,
  input  logic       strap_sysrst_i,
  output logic       sys_rst_o,
  output logic       ext_rst_o,
  output logic       run_o,
  output logic       bt_en_o,
  output logic       led_o
);
  logic arm, kick, expire, pulse;

  wdog_csr u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .berr_a_i  (berr_a_i),
    .berr_b_i  (berr_b_i),
    .pwrfail_i (pwrfail_i),
    .expire_i  (expire),
    .busy_i    (pulse),
    .arm_o     (arm),
    .kick_o    (kick),
    .bt_en_o   (bt_en_o),
    .led_o     (led_o),
    .rdata_o   (rdata_o)
  );

  wdog_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .kick_i   (kick),
    .expire_o (expire)
  );

  wdog_rstpulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (expire),
    .pulse_o (pulse)
  );

  assign sys_rst_o = pulse;
  assign ext_rst_o = pulse && strap_sysrst_i;
  assign run_o     = arm;
endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       berr_a_i,
  input logic       sys_rst_o,
  input logic       ext_rst_o,
  input logic       run_o
);
  // R2
  arm_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[0] && !run_o && !sys_rst_o |=> run_o);
  // R3
  no_sw_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $rose(sys_rst_o));
  // R5
  rst_from_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(run_o));
  // R6
  disarm_on_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> !run_o);
  // R7
  ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_o |-> sys_rst_o);
  // R8
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !run_o);
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_a_i |=> rdata_o[4]);
endmodule

bind wdog_ctl wdog_ctl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .berr_a_i  (berr_a_i),
  .sys_rst_o (sys_rst_o),
  .ext_rst_o (ext_rst_o),
  .run_o     (run_o)
);

// File: tb/sim_wdog_ctl.sv
`timescale 1ns/1ps
module sim_wdog_ctl;
  localparam int TO  = 64;
  localparam int RSTL = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       berr_a_i = 1'b0, berr_b_i = 1'b0, pwrfail_i = 1'b0, strap_sysrst_i = 1'b0;
  logic       sys_rst_o, ext_rst_o, run_o, bt_en_o, led_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the plain register bits
  logic m_bt = 0, m_led = 0, m_ea = 0, m_eb = 0, m_arm = 0;

  always #5 clk_i = ~clk_i;

  wdog_ctl #(.TIMEOUT_CYC(TO), .RST_CYC(RSTL)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .berr_a_i(berr_a_i), .berr_b_i(berr_b_i), .pwrfail_i(pwrfail_i),
    .strap_sysrst_i(strap_sysrst_i), .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o),
    .run_o(run_o), .bt_en_o(bt_en_o), .led_o(led_o)
  );

  function automatic logic [7:0] exp_rd(logic pf);
    return {1'b0, pf, m_eb, m_ea, m_led, m_bt, 1'b0, m_arm};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // write applied at the next posedge; returns at the following negedge
  task automatic wr(input logic [7:0] d, input logic ba = 0, input logic bb = 0);
    wr_i = 1'b1; wdata_i = d; berr_a_i = ba; berr_b_i = bb;
    @(posedge clk_i);
    m_bt  = d[2];
    m_led = d[3];
    if (d[7]) begin m_ea = 0; m_eb = 0; end
    if (ba) m_ea = 1;
    if (bb) m_eb = 1;
    @(negedge clk_i);
    wr_i = 1'b0; berr_a_i = 1'b0; berr_b_i = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(rdata_o === 8'h00, "R1 rdata", rdata_o, 0);
    chk({sys_rst_o, ext_rst_o, run_o, bt_en_o, led_o} === 5'b0, "R1 outputs",
        {sys_rst_o, ext_rst_o, run_o, bt_en_o, led_o}, 0);

    // R9 directed
    wr(8'h0C);
    chk(rdata_o === 8'h0C && bt_en_o && led_o, "R9 set", rdata_o, 8'h0C);
    wr(8'h04);
    chk(rdata_o === 8'h04 && bt_en_o && !led_o, "R9 partial", rdata_o, 8'h04);

    // R10 directed: sticky set, clear by bit 7, set wins
    berr_a_i = 1'b1; @(negedge clk_i); berr_a_i = 1'b0; m_ea = 1;
    @(negedge clk_i);
    chk(rdata_o[4] === 1'b1, "R10 sticky A", rdata_o, 8'h14);
    wr(8'h84);
    chk(rdata_o === 8'h04, "R10 clear", rdata_o, 8'h04);
    wr(8'h80, 1'b0, 1'b1);
    chk(rdata_o === 8'h20, "R10 set wins", rdata_o, 8'h20);
    pwrfail_i = 1'b1; #1;
    chk(rdata_o === 8'h60, "R10 pwrfail", rdata_o, 8'h60);

    // R9/R10 random: arm and kick bits masked off
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      logic pf;
      d = 8'($urandom) & 8'hFC;
      pf = 1'($urandom);
      pwrfail_i = pf;
      wr(d, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
      chk(rdata_o === exp_rd(pf), "R10 random", rdata_o, exp_rd(pf));
      chk(bt_en_o === m_bt && led_o === m_led, "R9 random", {bt_en_o, led_o}, {m_bt, m_led});
    end
    pwrfail_i = 1'b0;
    wr(8'h80);
    chk(rdata_o === 8'h00, "R10 clear all", rdata_o, 0);

    // R2 / R5 / R6 / R7 (strap low) / R8
    strap_sysrst_i = 1'b0;
    wr(8'h01); m_arm = 1;
    chk(run_o === 1'b1 && rdata_o === 8'h01, "R2 arm", rdata_o, 8'h01);
    repeat (TO - 1) @(negedge clk_i);
    chk(sys_rst_o === 1'b0, "R5 early", sys_rst_o, 0);
    @(negedge clk_i); m_arm = 0;
    chk(sys_rst_o === 1'b1, "R5 rise", sys_rst_o, 1);
    chk(run_o === 1'b0, "R6 disarm", run_o, 0);
    chk(ext_rst_o === 1'b0, "R7 strap low", ext_rst_o, 0);
    wr(8'h01);
    chk(sys_rst_o === 1'b1 && run_o === 1'b0, "R8 arm ignored", run_o, 0);
    for (int k = 3; k <= RSTL; k++) begin
      @(negedge clk_i);
      chk(sys_rst_o === 1'b1, "R5 width", sys_rst_o, 1);
    end
    @(negedge clk_i);
    chk(sys_rst_o === 1'b0, "R5 end", sys_rst_o, 0);
    chk(run_o === 1'b0 && rdata_o[0] === 1'b0, "R8 idle after pulse", rdata_o, 0);

    // R3 / R7 (strap high)
    strap_sysrst_i = 1'b1;
    wr(8'h01);
    wr(8'h00);
    chk(run_o === 1'b1 && rdata_o[0] === 1'b1, "R3 no disarm", rdata_o, 1);
    repeat (TO - 2) @(negedge clk_i);
    chk(sys_rst_o === 1'b0, "R3 early", sys_rst_o, 0);
    @(negedge clk_i);
    chk(sys_rst_o === 1'b1, "R3 timing kept", sys_rst_o, 1);
    chk(ext_rst_o === 1'b1, "R7 strap high", ext_rst_o, 1);
    repeat (RSTL) @(negedge clk_i);
    chk(sys_rst_o === 1'b0 && ext_rst_o === 1'b0, "R7 end", ext_rst_o, 0);

    // R4 random kick gaps
    wr(8'h01);
    for (int i = 0; i < 20; i++) begin
      int gap;
      gap = $urandom_range(1, TO - 1);
      for (int j = 1; j < gap; j++) begin
        chk(sys_rst_o === 1'b0, "R4 no expiry", sys_rst_o, 0);
        @(negedge clk_i);
      end
      wr(8'h02);
      chk(rdata_o[1] === 1'b0 && run_o === 1'b1, "R8 kick reads 0", rdata_o, 1);
    end
    repeat (TO - 1) @(negedge clk_i);
    chk(sys_rst_o === 1'b0, "R4 early", sys_rst_o, 0);
    @(negedge clk_i);
    chk(sys_rst_o === 1'b1, "R4 expiry after last kick", sys_rst_o, 1);
    repeat (RSTL + 1) @(negedge clk_i);

    report();
  end
endmodule